// File: doc/BRIEF.md
# Periodic Clock Offset Correction Unit

This block derives a one-second tick from a slow reference tick (nominally 32768 per second) and trims it for crystal error. Once per correction period it shortens or lengthens a single second by an even number of slow-clock pulses, so the average rate of the seconds tick moves by a small, programmable amount. The period is either a short or a long number of seconds (20 or 60 by default), chosen by a mode bit in the correction value.

Software writes an 8-bit correction value holding a period-select bit, a direction bit and a 6-bit magnitude code. A written value is not applied at once: it waits as a pending value, a busy flag stays high, and at the next period boundary the value becomes active and the flag drops. A write arriving while the flag is high is dropped. A separate enable input lets the trim be suppressed without stopping the seconds tick or the register handshake.

Top module: `octr_top`

## Requirements
- R1: After reset `busy` is 0, `act_cfg` is 8'h01 (short period, add direction, code 1, which means no trim) and every second lasts exactly DIV ticks.
- R2: The prescaler advances only on cycles where `tick` is 1; `sec_tick` is a one-cycle pulse issued one clock after the tick that ends a second.
- R3: Seconds are grouped into periods of SEC_SHORT seconds when `act_cfg[7]` is 0 and SEC_LONG seconds when it is 1; only the first second of each period is trimmed, all others last DIV ticks.
- R4: With `act_cfg[6]` = 0 (add) and code v = `act_cfg[5:0]`, the trimmed second lasts DIV − 2·(v−1) ticks; v = 0 is treated as no trim; code 63 gives the largest shortening, 124 ticks.
- R5: With `act_cfg[6]` = 1 (subtract), the trimmed second lasts DIV + 2·s ticks where s = ((~v) & 63) + 1 limited to at most 62, so codes 0 and 1 both give 124 extra ticks.
- R6: A write (`wr_en` = 1) with `busy` low stores `wr_data` as pending and raises `busy` on the next cycle; the pending value moves to `act_cfg` and `busy` falls in the same clock where the last second of a period ends, so the new trim first affects the next period; `act_cfg` changes at no other time.
- R7: A write while `busy` is high is ignored, including a write in the very clock where the pending value is latched.
- R8: A write with `busy` low in the same clock as a period boundary is accepted but is not applied at that boundary; it waits for the following one.
- R9: With `trim_en` low every second lasts DIV ticks, while pending values are still latched at boundaries and `busy` still clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per slow-clock pulse |
| trim_en | input | 1 | Trim applied when high |
| wr_en | input | 1 | Write strobe for the correction value |
| wr_data | input | MAG_W+2 | Correction value: [7] long period, [6] subtract, [5:0] code |
| busy | output | 1 | High while a written value is pending |
| act_cfg | output | MAG_W+2 | Correction value currently in force |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |

## Verification
The two functions that can meet in one clock are the boundary latch of the pending value and the acceptance of a new write. The bench times a write to land on the exact clock where a period's last second ends, once with `busy` low and once with `busy` high, by counting ticks from the previous seconds pulse. It then judges the outcome from `busy` and `act_cfg` in the following cycle and from the lengths of the trimmed seconds in the next two periods, which must show the accepted value deferred by one period and the rejected value never appearing.

// File: rtl/octr_pkg.sv
package octr_pkg;

   typedef enum logic {
      TRIM_ADD = 1'b0,
      TRIM_SUB = 1'b1
   } trim_dir_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/octr_trim_dec.sv
module octr_trim_dec #(
   parameter int unsigned MAG_W       = 6,
   parameter int unsigned STEP_PULSES = 2,
   parameter int unsigned MAX_STEPS   = 62,
   parameter int unsigned ADJ_W       = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAG_W:0]   dir_code,
   output logic [ADJ_W-1:0] adj,
   output logic             sub
);
   import octr_pkg::*;

   localparam int unsigned ST_W = MAG_W + 1;

   logic [MAG_W-1:0] code;
   trim_dir_e        dir;
   logic [ST_W-1:0]  raw_add;
   logic [ST_W-1:0]  raw_sub;
   logic [ST_W-1:0]  raw;
   logic [ST_W-1:0]  steps;

   assign code = dir_code[MAG_W-1:0];
   assign dir  = trim_dir_e'(dir_code[MAG_W]);
   assign sub  = (dir == TRIM_SUB);

   always_comb begin
      raw_add = (code == '0) ? '0 : ({1'b0, code} - ST_W'(1));
      raw_sub = {1'b0, ~code} + ST_W'(1);
      raw     = (dir == TRIM_SUB) ? raw_sub : raw_add;
      steps   = (raw > ST_W'(MAX_STEPS)) ? ST_W'(MAX_STEPS) : raw;
   end

   generate
      if ((STEP_PULSES & (STEP_PULSES - 1)) == 0) begin : g_shift
         localparam int unsigned SH = $clog2(STEP_PULSES);
         assign adj = ADJ_W'(steps) << SH;
      end else begin : g_mult
         assign adj = ADJ_W'(32'(steps) * STEP_PULSES);
      end
   endgenerate

   // R5: the applied pulse count never exceeds the clamped maximum
   p_adj_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      adj <= ADJ_W'(STEP_PULSES * MAX_STEPS));

endmodule

// File: rtl/octr_cfg_reg.sv
module octr_cfg_reg #(
   parameter int unsigned CFG_W   = 8,
   parameter logic [CFG_W-1:0] NEUTRAL = 8'h01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             boundary,
   output logic [CFG_W-1:0] act,
   output logic             busy
);

   logic [CFG_W-1:0] pend_q;
   logic [CFG_W-1:0] act_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= NEUTRAL;
         act_q  <= NEUTRAL;
         busy_q <= 1'b0;
      end else if (boundary && busy_q) begin
         act_q  <= pend_q;
         busy_q <= 1'b0;
      end else if (wr_en && !busy_q) begin
         pend_q <= wr_data;
         busy_q <= 1'b1;
      end
   end

   assign act  = act_q;
   assign busy = busy_q;

   // R6: an accepted write is held as pending and raises busy
   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy_q) |=> (busy_q && pend_q == $past(wr_data)));

   // R6: the boundary moves pending to active and drops busy
   p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && busy_q) |=> (!busy_q && act_q == $past(pend_q)));

   // R6: the active value moves only at a boundary
   p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(act_q));

   // R7: a write while busy leaves the pending value alone
   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy_q) |=> $stable(pend_q));

   // R8: a write meeting a boundary with busy low is deferred
   p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !busy_q && wr_en) |=> (busy_q && $stable(act_q)));

endmodule

// File: rtl/octr_presc.sv
module octr_presc #(
   parameter int unsigned DIV      = 32768,
   parameter int unsigned MAX_ADJ  = 124,
   parameter int unsigned PSC_W    = 16,
   parameter int unsigned ADJ_W    = 7,
   parameter bit          REG_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             trim_on,
   input  logic             sub,
   input  logic [ADJ_W-1:0] adj,
   output logic             wrap,
   output logic             sec_tick
);

   localparam logic [PSC_W-1:0] BASE   = PSC_W'(DIV - 1);
   localparam logic [PSC_W-1:0] CEIL   = PSC_W'(DIV - 1 + MAX_ADJ);

   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] term;

   always_comb begin
      if (!trim_on)  term = BASE;
      else if (sub)  term = BASE + PSC_W'(adj);
      else           term = BASE - PSC_W'(adj);
   end

   assign wrap = tick && (psc_q >= term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     psc_q <= '0;
      else if (tick)  psc_q <= wrap ? '0 : psc_q + PSC_W'(1);
   end

   generate
      if (REG_TICK) begin : g_reg_tick
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= wrap;
         end
         assign sec_tick = tick_q;
      end else begin : g_comb_tick
         assign sec_tick = wrap;
      end
   endgenerate

   // R2: the prescaler holds on cycles without a tick
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(psc_q));

   // R2: a second end restarts the count
   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (psc_q == '0));

   // R5: the count never passes the longest trimmed second
   p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
      psc_q <= CEIL);

endmodule

// File: rtl/octr_sec_ctr.sv
module octr_sec_ctr #(
   parameter int unsigned SEC_SHORT = 20,
   parameter int unsigned SEC_LONG  = 60,
   parameter int unsigned SEC_W     = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic long_mode,
   output logic corr_sec,
   output logic boundary
);

   logic [SEC_W-1:0] sec_q;
   logic [SEC_W-1:0] last_idx;
   logic             last;

   assign last_idx = long_mode ? SEC_W'(SEC_LONG - 1) : SEC_W'(SEC_SHORT - 1);
   assign last     = (sec_q >= last_idx);
   assign boundary = wrap && last;
   assign corr_sec = (sec_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sec_q <= '0;
      else if (wrap)  sec_q <= last ? '0 : sec_q + SEC_W'(1);
   end

   // R3: the second index moves only when a second ends
   p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(sec_q));

   // R3: each period begins with its trimmed second
   p_period_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> corr_sec);

   // R3: the index stays inside the longest period
   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q <= SEC_W'(SEC_LONG > SEC_SHORT ? SEC_LONG - 1 : SEC_SHORT - 1));

endmodule

// File: rtl/octr_top.sv
module octr_top #(
   parameter int unsigned DIV         = 32768,
   parameter int unsigned MAG_W       = 6,
   parameter int unsigned STEP_PULSES = 2,
   parameter int unsigned MAX_STEPS   = 62,
   parameter int unsigned SEC_SHORT   = 20,
   parameter int unsigned SEC_LONG    = 60,
   parameter bit          REG_TICK    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             trim_en,
   input  logic             wr_en,
   input  logic [MAG_W+1:0] wr_data,
   output logic             busy,
   output logic [MAG_W+1:0] act_cfg,
   output logic             sec_tick
);
   import octr_pkg::*;

   localparam int unsigned CFG_W   = MAG_W + 2;
   localparam int unsigned MAX_ADJ = STEP_PULSES * MAX_STEPS;
   localparam int unsigned ADJ_W   = $clog2(MAX_ADJ + 1);
   localparam int unsigned PSC_W   = $clog2(DIV + MAX_ADJ);
   localparam int unsigned SEC_W   = $clog2(max2(SEC_SHORT, SEC_LONG));
   localparam logic [CFG_W-1:0] NEUTRAL = CFG_W'(1);

   generate
      if (DIV <= MAX_ADJ + 1) begin : g_bad_div
         $error("DIV must exceed the largest trim plus one");
      end
      if (MAX_STEPS >= (1 << MAG_W)) begin : g_bad_steps
         $error("MAX_STEPS must fit the magnitude code");
      end
      if (SEC_SHORT < 2 || SEC_LONG < 2) begin : g_bad_period
         $error("periods must span at least two seconds");
      end
      if (STEP_PULSES < 1) begin : g_bad_step
         $error("STEP_PULSES must be at least one");
      end
   endgenerate

   logic             boundary;
   logic             corr_sec;
   logic             wrap;
   logic             sub;
   logic [ADJ_W-1:0] adj;
   logic [CFG_W-1:0] act;

   octr_cfg_reg #(
      .CFG_W   (CFG_W),
      .NEUTRAL (NEUTRAL)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .boundary (boundary),
      .act      (act),
      .busy     (busy)
   );

   octr_trim_dec #(
      .MAG_W       (MAG_W),
      .STEP_PULSES (STEP_PULSES),
      .MAX_STEPS   (MAX_STEPS),
      .ADJ_W       (ADJ_W)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_code (act[MAG_W:0]),
      .adj      (adj),
      .sub      (sub)
   );

   octr_presc #(
      .DIV      (DIV),
      .MAX_ADJ  (MAX_ADJ),
      .PSC_W    (PSC_W),
      .ADJ_W    (ADJ_W),
      .REG_TICK (REG_TICK)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .trim_on  (corr_sec && trim_en),
      .sub      (sub),
      .adj      (adj),
      .wrap     (wrap),
      .sec_tick (sec_tick)
   );

   octr_sec_ctr #(
      .SEC_SHORT (SEC_SHORT),
      .SEC_LONG  (SEC_LONG),
      .SEC_W     (SEC_W)
   ) u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .wrap      (wrap),
      .long_mode (act[MAG_W+1]),
      .corr_sec  (corr_sec),
      .boundary  (boundary)
   );

   assign act_cfg = act;

endmodule

// File: tb/tb_octr_top.sv
`timescale 1ns/1ps
module tb_octr_top;

   localparam int DIV  = 160;
   localparam int SS   = 3;
   localparam int SL   = 5;
   localparam int TDIV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       trim_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       busy;
   logic [7:0] act_cfg;
   logic       sec_tick;

   octr_top #(
      .DIV       (DIV),
      .SEC_SHORT (SS),
      .SEC_LONG  (SL)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .trim_en  (trim_en),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .busy     (busy),
      .act_cfg  (act_cfg),
      .sec_tick (sec_tick)
   );

   always #2 clk = ~clk;

   typedef struct {
      int    cyc;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [7:0] c, input bit en);
      int v;
      int s;
      v = int'(c[5:0]);
      if (!en) return DIV;
      if (!c[6]) begin
         s = (v == 0) ? 0 : v - 1;
         return DIV - 2 * s;
      end
      s = ((~v) & 63) + 1;
      if (s > 62) s = 62;
      return DIV + 2 * s;
   endfunction

   function automatic int per_len(input logic [7:0] c);
      return c[7] ? SL : SS;
   endfunction

   // driver side of the scoreboard: expected second lengths for one period
   task automatic push_period(input logic [7:0] c, input bit en, input string tag);
      exp_t e;
      e.cyc = exp_len(c, en) * TDIV;
      e.tag = tag;
      q.push_back(e);
      for (int i = 1; i < per_len(c); i++) begin
         e.cyc = DIV * TDIV;
         e.tag = "R3 untrimmed second";
         q.push_back(e);
      end
   endtask

   task automatic wait_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (sec_tick !== 1'b1);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // write landing on the clock that ends the current second of length len
   task automatic timed_write(input logic [7:0] d, input int len);
      repeat (len * TDIV - 1) @(negedge clk);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // tick generator
   initial begin
      int ph;
      ph = 0;
      forever begin
         @(negedge clk);
         ph   = (ph + 1) % TDIV;
         tick = (ph == 0);
      end
   end

   // monitor side of the scoreboard
   initial begin
      int  cnt;
      bit  seen;
      exp_t e;
      cnt  = 0;
      seen = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            cnt  = 0;
            seen = 1'b0;
         end else begin
            cnt++;
            if (sec_tick) begin
               if (cnt == 1) check(1'b0, "R2 sec_tick wider than one cycle", cnt, DIV * TDIV);
               if (seen) begin
                  if (q.size() == 0) begin
                     check(1'b0, "R3 unexpected second", cnt, 0);
                  end else begin
                     e = q.pop_front();
                     check(cnt == e.cyc, e.tag, cnt, e.cyc);
                  end
               end
               seen = 1'b1;
               cnt  = 0;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check(busy == 1'b0, "R1 busy in reset", busy, 0);
      check(act_cfg == 8'h01, "R1 act_cfg in reset", act_cfg, 8'h01);
      check(sec_tick == 1'b0, "R1 sec_tick in reset", sec_tick, 0);
      rst_n = 1'b1;

      // first period after reset: neutral trim, short period
      push_period(8'h01, 1'b1, "R1 neutral second");
      void'(q.pop_front());
      wait_pulses(3);
      check(busy == 1'b0, "R1 busy after reset period", busy, 0);

      // add trim v=5: 8 ticks shorter, deferred by one period
      do_write(8'h05);
      check(busy == 1'b1, "R6 busy after write", busy, 1);
      check(act_cfg == 8'h01, "R6 act before boundary", act_cfg, 8'h01);
      push_period(8'h01, 1'b1, "R6 old trim until boundary");
      wait_pulses(3);
      check(busy == 1'b0, "R6 busy cleared at boundary", busy, 0);
      check(act_cfg == 8'h05, "R6 act latched", act_cfg, 8'h05);
      push_period(8'h05, 1'b1, "R4 add code 5");
      wait_pulses(3);

      // subtract, long period, code 0x3A: 12 ticks longer; second write dropped
      do_write(8'hFA);
      do_write(8'h41);
      check(busy == 1'b1, "R7 busy held after ignored write", busy, 1);
      push_period(8'h05, 1'b1, "R4 add code 5 again");
      wait_pulses(3);
      check(act_cfg == 8'hFA, "R7 ignored write not latched", act_cfg, 8'hFA);
      push_period(8'hFA, 1'b1, "R5 subtract code 0x3A long period");
      wait_pulses(SL);

      // add code 0: no trim
      do_write(8'h00);
      push_period(8'hFA, 1'b1, "R5 subtract code 0x3A second period");
      wait_pulses(SL);
      check(act_cfg == 8'h00, "R3 mode back to short", act_cfg, 8'h00);
      push_period(8'h00, 1'b1, "R4 add code 0 gives no trim");
      wait_pulses(SS);

      // subtract code 1: clamped to 124 extra ticks
      do_write(8'h41);
      push_period(8'h00, 1'b1, "R4 add code 0 second period");
      wait_pulses(SS);
      push_period(8'h41, 1'b1, "R5 subtract clamp to 124");
      wait_pulses(SS);

      // trim disabled while code 0x3F is written and latched
      trim_en = 1'b0;
      do_write(8'h3F);
      push_period(8'h41, 1'b0, "R9 disabled subtract");
      wait_pulses(SS);
      check(busy == 1'b0, "R9 busy clears while disabled", busy, 0);
      check(act_cfg == 8'h3F, "R9 latch while disabled", act_cfg, 8'h3F);
      push_period(8'h3F, 1'b0, "R9 disabled add");
      wait_pulses(SS);
      trim_en = 1'b1;
      push_period(8'h3F, 1'b1, "R4 add code 63 largest shortening");
      wait_pulses(SS);

      // write meets boundary with busy low: deferred one period
      push_period(8'h3F, 1'b1, "R8 trim before colliding write");
      wait_pulses(2);
      timed_write(8'h07, DIV);
      check(sec_tick == 1'b1, "R8 write aligned with boundary", sec_tick, 1);
      check(busy == 1'b1, "R8 collision write accepted", busy, 1);
      check(act_cfg == 8'h3F, "R8 not applied at same boundary", act_cfg, 8'h3F);
      push_period(8'h3F, 1'b1, "R8 old trim one more period");
      wait_pulses(SS);
      check(act_cfg == 8'h07, "R8 applied at next boundary", act_cfg, 8'h07);
      check(busy == 1'b0, "R8 busy cleared", busy, 0);
      push_period(8'h07, 1'b1, "R8 deferred add code 7");
      wait_pulses(SS);

      // write meets boundary with busy high: dropped
      do_write(8'h89);
      push_period(8'h07, 1'b1, "R7 trim before latch");
      wait_pulses(2);
      timed_write(8'h0B, DIV);
      check(sec_tick == 1'b1, "R7 write aligned with boundary", sec_tick, 1);
      check(busy == 1'b0, "R7 collision write dropped", busy, 0);
      check(act_cfg == 8'h89, "R7 pending latched at collision", act_cfg, 8'h89);
      push_period(8'h89, 1'b1, "R3 long period add code 9");
      wait_pulses(SL);
      check(act_cfg == 8'h89, "R7 dropped write never applied", act_cfg, 8'h89);
      check(busy == 1'b0, "R7 busy stays low", busy, 0);

      repeat (20) @(negedge clk);
      check(q.size() == 0, "R3 all expected seconds observed", q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule